// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block sits on the device side of a serial nonvolatile memory, behind the logic that shifts and frames instructions. It owns the status byte: a write-in-progress flag, a write-enable latch, a two-bit block-protect field and a protect-enable bit. It receives single-cycle instruction events (enable writes, disable writes, write status, write array) together with the level of an active-low write-protect pin. From these it decides whether each status write and each array write may start, and it keeps the latch and the flags up to date. The internal program cycle is timed elsewhere; a one-cycle done pulse from that timer ends it.

The parameter `SMALL_SCHEME` picks the protection scheme. With `SMALL_SCHEME = 1` (small-density parts), a low pin clears the latch and keeps it clear, so every write is blocked. With `SMALL_SCHEME = 0` (large-density parts), the pin matters only when the protect-enable bit is set. It then locks the status register, and therefore the block-protect field. Array writes are gated only by the block-protect range.

Top module: `nvm_status_guard`

## Requirements
- R1: A status write or array write is accepted only while the write-enable latch (status bit 1) is 1. A rejected instruction gives no go pulse and does not set the busy flag.
- R2: An enable-writes event sets the latch, visible one clock later. No other event sets it.
- R3: After reset the status byte reads 0x00, and bits 6:4 always read 0.
- R4: A disable-writes event clears the latch one clock later.
- R5: An accepted write pulses its go output for one cycle and sets the busy flag (status bit 0) in the same cycle. The latch stays 1 during the program cycle. Both the busy flag and the latch clear one clock after the done pulse.
- R6: A rejected write or status write leaves the latch unchanged. For example, a write to a protected address leaves it at 1.
- R7: Block-protect field (status bits 3:2) encoding: 00 protects nothing, 01 protects the top quarter of the address space, 10 protects the top half, and 11 protects all of it. An array write to a protected address is rejected.
- R8: An accepted status write takes its new block-protect field and protect-enable bit (status bit 7) from its inputs. The new values appear only when the program cycle ends, together with the clearing of the busy flag.
- R9: While the busy flag is 1, all instruction events are ignored. A done pulse while not busy has no effect.
- R10: Small scheme: a low pin clears the latch one clock later and holds it clear, and enable-writes events are ignored while the pin stays low. Raising the pin does not set the latch again. The protect-enable bit always reads 0.
- R11: Large scheme: the pin is ignored while the protect-enable bit is 0. While that bit is 1, a low pin rejects status writes. The pin never rejects array writes.
- R12: Events arriving in the same cycle are resolved in the priority order status write, array write, disable, enable. Only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Write-protect pin level, active low |
| ev_wren_i | input | 1 | Enable-writes instruction event |
| ev_wrdi_i | input | 1 | Disable-writes instruction event |
| ev_wrsr_i | input | 1 | Status-write instruction event |
| wrsr_bp_i | input | 2 | Block-protect value carried by the status write |
| wrsr_wpen_i | input | 1 | Protect-enable value carried by the status write |
| ev_write_i | input | 1 | Array-write instruction event |
| wr_addr_i | input | ADDR_W | Target address of the array write |
| cycle_done_i | input | 1 | End of the internal program cycle |
| status_o | output | 8 | Status byte |
| arr_go_o | output | 1 | Array program cycle starts |
| sr_go_o | output | 1 | Status program cycle starts |

## Verification
Array writes are aimed at addresses just below and just above each protection boundary, under every block-protect setting. This separates a threshold that is off by one quarter from a correct one, and shows that a rejected write keeps the latch. Status writes are tried with the pin high and low and with the protect-enable bit clear and set. This shows that the large scheme ignores the pin until the bit is set and that the pin never blocks array writes. A second instance in the small scheme receives a pin pulse followed by enable events. This shows that the latch is forced clear and stays clear until a fresh enable after the pin rises. Events issued during a program cycle, simultaneous events, and done pulses while idle confirm the ignore and priority rules.

// File: rtl/nvm_sg_pkg.sv
package nvm_sg_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_WIP  = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_BP0  = 2;
    localparam int BIT_WPEN = 7;

    typedef struct packed {
        logic       wel;
        logic       wip;
        logic [1:0] bp;
        logic       wpen;
        logic       pend_sr;
        logic [1:0] pend_bp;
        logic       pend_wpen;
        logic       arr_go;
        logic       sr_go;
    } sg_state_t;

    localparam sg_state_t SG_RESET = '0;

endpackage

// File: rtl/nvm_sg_range.sv
module nvm_sg_range #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int SHIFT = ADDR_W - 2;

    logic [1:0]        quarter_first;
    logic [ADDR_W-1:0] boundary;

    always_comb begin
        unique case (bp_i)
            2'b01:   quarter_first = 2'd3;
            2'b10:   quarter_first = 2'd2;
            default: quarter_first = 2'd0;
        endcase
        boundary = ADDR_W'(quarter_first) << SHIFT;
        hit_o    = (bp_i != 2'b00) && (addr_i >= boundary);
    end
endmodule

// File: rtl/nvm_sg_policy.sv
module nvm_sg_policy #(
    parameter bit SMALL_SCHEME = 1'b0
) (
    input  logic wel_i,
    input  logic wpen_i,
    input  logic wp_ni,
    input  logic prot_hit_i,
    output logic write_ok_o,
    output logic sr_ok_o,
    output logic wel_kill_o
);
    generate
        if (SMALL_SCHEME) begin : g_small
            logic unused_wpen;
            assign unused_wpen = wpen_i;
            assign wel_kill_o  = !wp_ni;
            assign write_ok_o  = wel_i && wp_ni && !prot_hit_i;
            assign sr_ok_o     = wel_i && wp_ni;
        end else begin : g_large
            assign wel_kill_o  = 1'b0;
            assign write_ok_o  = wel_i && !prot_hit_i;
            assign sr_ok_o     = wel_i && !(wpen_i && !wp_ni);
        end
    endgenerate
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
    import nvm_sg_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter bit SMALL_SCHEME = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wp_ni,
    input  logic              ev_wren_i,
    input  logic              ev_wrdi_i,
    input  logic              ev_wrsr_i,
    input  logic [1:0]        wrsr_bp_i,
    input  logic              wrsr_wpen_i,
    input  logic              ev_write_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              arr_go_o,
    output logic              sr_go_o
);
    sg_state_t st_d, st_q;
    logic      prot_hit, write_ok, sr_ok, wel_kill;

    nvm_sg_range #(.ADDR_W(ADDR_W)) range_i (
        .bp_i   (st_q.bp),
        .addr_i (wr_addr_i),
        .hit_o  (prot_hit)
    );

    nvm_sg_policy #(.SMALL_SCHEME(SMALL_SCHEME)) policy_i (
        .wel_i      (st_q.wel),
        .wpen_i     (st_q.wpen),
        .wp_ni      (wp_ni),
        .prot_hit_i (prot_hit),
        .write_ok_o (write_ok),
        .sr_ok_o    (sr_ok),
        .wel_kill_o (wel_kill)
    );

    always_comb begin
        st_d        = st_q;
        st_d.arr_go = 1'b0;
        st_d.sr_go  = 1'b0;
        if (st_q.wip) begin
            if (cycle_done_i) begin
                st_d.wip = 1'b0;
                st_d.wel = 1'b0;
                if (st_q.pend_sr) begin
                    st_d.bp   = st_q.pend_bp;
                    st_d.wpen = SMALL_SCHEME ? 1'b0 : st_q.pend_wpen;
                end
            end
        end else if (ev_wrsr_i) begin
            if (sr_ok) begin
                st_d.wip       = 1'b1;
                st_d.pend_sr   = 1'b1;
                st_d.pend_bp   = wrsr_bp_i;
                st_d.pend_wpen = wrsr_wpen_i;
                st_d.sr_go     = 1'b1;
            end
        end else if (ev_write_i) begin
            if (write_ok) begin
                st_d.wip     = 1'b1;
                st_d.pend_sr = 1'b0;
                st_d.arr_go  = 1'b1;
            end
        end else if (ev_wrdi_i) begin
            st_d.wel = 1'b0;
        end else if (ev_wren_i) begin
            st_d.wel = 1'b1;
        end
        if (wel_kill) begin
            st_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= SG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[BIT_WIP]           = st_q.wip;
        status_o[BIT_WEL]           = st_q.wel;
        status_o[BIT_BP0+1:BIT_BP0] = st_q.bp;
        status_o[BIT_WPEN]          = st_q.wpen;
    end

    assign arr_go_o = st_q.arr_go;
    assign sr_go_o  = st_q.sr_go;
endmodule

// File: rtl/nvm_sg_chk.sv
module nvm_sg_chk #(
    parameter int ADDR_W       = 8,
    parameter bit SMALL_SCHEME = 1'b0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wp_ni,
    input logic              ev_wren_i,
    input logic              ev_wrsr_i,
    input logic              ev_write_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              cycle_done_i,
    input logic [7:0]        status_o,
    input logic              arr_go_o,
    input logic              sr_go_o
);
    logic unused_addr;
    assign unused_addr = ^wr_addr_i;

    AST_WEL_SET_ONLY_BY_WREN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[1]) |-> $past(ev_wren_i)); // R2

    AST_GO_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_go_o || sr_go_o) |-> $past(status_o[1])); // R1

    AST_GO_STARTS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_go_o || sr_go_o) |-> (status_o[0] && !$past(status_o[0]))); // R5

    AST_WEL_CLEARS_WITH_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[0]) |-> !status_o[1]); // R5

    AST_WIP_ENDS_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[0]) |-> $past(cycle_done_i)); // R9

    AST_BUSY_IGNORES_EVENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[0] && !cycle_done_i) |=> (status_o[0] && !arr_go_o && !sr_go_o)); // R9

    AST_FAILED_WRITE_KEEPS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_write_i && !ev_wrsr_i && !status_o[0] && status_o[1] && (wp_ni || !SMALL_SCHEME))
        |=> (arr_go_o || status_o[1])); // R6

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[0]) |-> (status_o[6:4] == 3'b000)); // R3

    generate
        if (SMALL_SCHEME) begin : g_small
            AST_PIN_KILLS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !wp_ni |=> !status_o[1]); // R10
        end else begin : g_large
            AST_PIN_LOCKS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (status_o[7] && !wp_ni && ev_wrsr_i) |=> !sr_go_o); // R11
        end
    endgenerate
endmodule

bind nvm_status_guard nvm_sg_chk #(.ADDR_W(ADDR_W), .SMALL_SCHEME(SMALL_SCHEME)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wp_ni        (wp_ni),
    .ev_wren_i    (ev_wren_i),
    .ev_wrsr_i    (ev_wrsr_i),
    .ev_write_i   (ev_write_i),
    .wr_addr_i    (wr_addr_i),
    .cycle_done_i (cycle_done_i),
    .status_o     (status_o),
    .arr_go_o     (arr_go_o),
    .sr_go_o      (sr_go_o)
);

// File: tb/nvm_status_guard_tb_top.sv
module nvm_status_guard_tb_top;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_l = 1'b1, wp_s = 1'b1;
    logic              ev_wren = 1'b0, ev_wrdi = 1'b0, ev_wrsr = 1'b0, ev_write = 1'b0;
    logic [1:0]        sr_bp = '0;
    logic              sr_wpen = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              done = 1'b0;
    logic [7:0]        st_l, st_s;
    logic              ago_l, sgo_l, ago_s, sgo_s;
    int                n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    nvm_status_guard #(.ADDR_W(ADDR_W), .SMALL_SCHEME(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_l),
        .ev_wren_i(ev_wren), .ev_wrdi_i(ev_wrdi), .ev_wrsr_i(ev_wrsr),
        .wrsr_bp_i(sr_bp), .wrsr_wpen_i(sr_wpen),
        .ev_write_i(ev_write), .wr_addr_i(addr), .cycle_done_i(done),
        .status_o(st_l), .arr_go_o(ago_l), .sr_go_o(sgo_l)
    );

    nvm_status_guard #(.ADDR_W(ADDR_W), .SMALL_SCHEME(1'b1)) dut_s (
        .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_s),
        .ev_wren_i(ev_wren), .ev_wrdi_i(ev_wrdi), .ev_wrsr_i(ev_wrsr),
        .wrsr_bp_i(sr_bp), .wrsr_wpen_i(sr_wpen),
        .ev_write_i(ev_write), .wr_addr_i(addr), .cycle_done_i(done),
        .status_o(st_s), .arr_go_o(ago_s), .sr_go_o(sgo_s)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wren();
        ev_wren = 1'b1; @(negedge clk); ev_wren = 1'b0;
    endtask
    task automatic wrdi();
        ev_wrdi = 1'b1; @(negedge clk); ev_wrdi = 1'b0;
    endtask
    task automatic wrsr(input logic [1:0] bp, input logic wpen);
        ev_wrsr = 1'b1; sr_bp = bp; sr_wpen = wpen;
        @(negedge clk); ev_wrsr = 1'b0;
    endtask
    task automatic write(input logic [ADDR_W-1:0] a);
        ev_write = 1'b1; addr = a; @(negedge clk); ev_write = 1'b0;
    endtask
    task automatic finish_cycle();
        done = 1'b1; @(negedge clk); done = 1'b0;
    endtask

    // large-scheme write attempt: expect accept or reject, then end the cycle
    task automatic try_write(input string req, input logic [ADDR_W-1:0] a,
                             input logic ok, input logic [7:0] st_before);
        write(a);
        check({req, " go"}, {7'd0, ago_l}, {7'd0, ok});
        if (ok) begin
            check({req, " busy"}, st_l, st_before | 8'h01);
            finish_cycle();
            check({req, " end"}, st_l, st_before & 8'hFC);
        end else begin
            check({req, " kept WEL"}, st_l, st_before);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R3 reset large", st_l, 8'h00);
        check("R3 reset small", st_s, 8'h00);
        wrsr(2'b11, 1'b1);
        check("R1 wrsr without WEL go", {7'd0, sgo_l}, 8'h00);
        check("R1 wrsr without WEL status", st_l, 8'h00);
        write(8'h10);
        check("R1 write without WEL go", {7'd0, ago_l}, 8'h00);
        check("R1 write without WEL status", st_l, 8'h00);
    endtask

    task automatic t_latch();
        wren();
        check("R2 wren sets WEL", st_l, 8'h02);
        wrdi();
        check("R4 wrdi clears WEL", st_l, 8'h00);
        ev_wren = 1'b1; ev_wrdi = 1'b1; @(negedge clk); ev_wren = 1'b0; ev_wrdi = 1'b0;
        check("R12 wrdi beats wren", st_l, 8'h00);
        wren();
        ev_wrdi = 1'b1; ev_write = 1'b1; addr = 8'h05;
        @(negedge clk); ev_wrdi = 1'b0; ev_write = 1'b0;
        check("R12 write beats wrdi", {7'd0, ago_l}, 8'h01);
        finish_cycle();
        check("R12 write beats wrdi end", st_l, 8'h00);
    endtask

    task automatic t_array_cycle();
        wren();
        write(8'h10);
        check("R5 array go", {7'd0, ago_l}, 8'h01);
        check("R5 busy with WEL", st_l, 8'h03);
        @(negedge clk);
        check("R5 go single cycle", {7'd0, ago_l}, 8'h00);
        wrdi();
        check("R9 wrdi ignored while busy", st_l, 8'h03);
        wrsr(2'b11, 1'b0);
        check("R9 wrsr ignored while busy", {7'd0, sgo_l}, 8'h00);
        check("R5 WEL held until done", st_l, 8'h03);
        finish_cycle();
        check("R5 done clears WIP and WEL", st_l, 8'h00);
        finish_cycle();
        check("R9 idle done ignored", st_l, 8'h00);
    endtask

    task automatic t_block_protect();
        wren();
        wrsr(2'b11, 1'b0);
        check("R8 wrsr go", {7'd0, sgo_l}, 8'h01);
        check("R8 bp not yet applied", st_l, 8'h03);
        finish_cycle();
        check("R8 bp applied at end", st_l, 8'h0C);
        wren();
        try_write("R7 bp11 addr 00", 8'h00, 1'b0, 8'h0E);
        try_write("R6 bp11 addr FF", 8'hFF, 1'b0, 8'h0E);
        wrsr(2'b01, 1'b0); finish_cycle();
        check("R8 bp01 applied", st_l, 8'h04);
        wren();
        try_write("R7 bp01 addr C0", 8'hC0, 1'b0, 8'h06);
        try_write("R7 bp01 addr BF", 8'hBF, 1'b1, 8'h06);
        wren(); wrsr(2'b10, 1'b0); finish_cycle();
        check("R8 bp10 applied", st_l, 8'h08);
        wren();
        try_write("R7 bp10 addr 80", 8'h80, 1'b0, 8'h0A);
        try_write("R7 bp10 addr 7F", 8'h7F, 1'b1, 8'h0A);
        wren(); wrsr(2'b00, 1'b0); finish_cycle();
        wren();
        try_write("R7 bp00 addr FF", 8'hFF, 1'b1, 8'h02);
    endtask

    task automatic t_pin_large();
        wp_l = 1'b0;
        wren(); wrsr(2'b00, 1'b0);
        check("R11 pin ignored without WPEN", {7'd0, sgo_l}, 8'h01);
        finish_cycle();
        wren(); wrsr(2'b00, 1'b1); finish_cycle();
        check("R11 WPEN set", st_l, 8'h80);
        wren();
        wrsr(2'b11, 1'b0);
        check("R11 locked wrsr go", {7'd0, sgo_l}, 8'h00);
        check("R11 locked wrsr keeps WEL", st_l, 8'h82);
        try_write("R11 pin does not block array", 8'h20, 1'b1, 8'h82);
        wp_l = 1'b1;
        wren(); wrsr(2'b00, 1'b0);
        check("R11 unlocked wrsr go", {7'd0, sgo_l}, 8'h01);
        finish_cycle();
        check("R11 WPEN cleared", st_l, 8'h00);
    endtask

    task automatic t_small();
        do_reset();
        check("R3 small reset again", st_s, 8'h00);
        wren(); wrsr(2'b11, 1'b1); finish_cycle();
        check("R10 small WPEN reads 0", st_s, 8'h0C);
        wren();
        check("R2 small wren", st_s, 8'h0E);
        wp_s = 1'b0; @(negedge clk);
        check("R10 pin low clears WEL", st_s, 8'h0C);
        wren();
        check("R10 wren ignored while pin low", st_s, 8'h0C);
        wp_s = 1'b1; @(negedge clk);
        check("R10 pin high does not set WEL", st_s, 8'h0C);
        wren();
        check("R10 fresh wren after pin high", st_s, 8'h0E);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_latch();
        t_array_cycle();
        t_block_protect();
        t_pin_large();
        t_small();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule